// File: doc/BRIEF.md
# Inter-Core Interrupt Generator

This block carries software-raised interrupts between the cores of a small cluster of up to four cores. All cores share one command port. Each command names the issuing core, an operation and one core index as its parameter. The block keeps, for every target core, a bitmap of the cores that have raised an interrupt toward it. It drives one interrupt line per core, and that line is high while the core's bitmap holds any set bit.

A sender can ask whether a target already has something pending before it raises another interrupt. A target that takes the interrupt reads its sender bitmap. It then acknowledges each sender one at a time. Sends from several cores that arrive before the acknowledge merge into the one asserted line. The shared readback register returns the result of the last status or source query.

Top module: `xirq_gen_top`

## Requirements
- R1: A raise command (opcode 1) from core C with parameter T (T different from C) sets bit C of target T's sender bitmap. `irq[T]` is high after the next clock edge.
- R2: A raise command whose parameter equals the issuing core changes no bitmap and no interrupt line.
- R3: A status query (opcode 2) with parameter T loads the readback with 1 when target T has any sender bit set, and with 0 otherwise. The value appears after the next clock edge.
- R4: A source query (opcode 3) loads the readback with the issuing core's sender bitmap. Bit k of the readback is core k.
- R5: Raise commands from several cores toward one target before any acknowledge leave a single asserted line. The source query then shows one bit for each of those senders.
- R6: An acknowledge command (opcode 4) from core C with parameter S clears only bit S of core C's bitmap. Acknowledging a bit that is clear changes nothing.
- R7: `irq[T]` stays high while any bit of T's bitmap is set. It is low after the clock edge that clears the last bit.
- R8: The readback changes only on the edge after a status or source query. Opcode 0 and opcodes 5 to 7 change neither the readback nor any bitmap.
- R9: While `rst` is high, all bitmaps are cleared and `irq` and `readback` are 0.
- R10: A raise toward a sender bit that is already set leaves all state unchanged.
- R11: A command whose issuing core, or whose target or sender parameter, is NUM_CORES or above has no effect on the bitmaps, the lines or the readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_core | input | 2 | Index of the issuing core |
| cmd_op | input | 3 | Operation code |
| cmd_param | input | 2 | Target or sender core index |
| readback | output | NUM_CORES | Result of the last status or source query |
| irq | output | NUM_CORES | Interrupt line for each core |

## Verification
The bench builds one instance with NUM_CORES = 4, where every 2-bit index names a real core. On this instance it exercises sends, merging, duplicate raises and acknowledges in every bit position. It builds a second instance with NUM_CORES = 3. There the index 3 fits in the port but names no core, so this instance exercises the rule that ignores out-of-range issuers, targets and senders.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int MAX_CORES = 4;
    localparam int ID_W      = $clog2(MAX_CORES);

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_RAISE  = 3'd1,
        OP_STATUS = 3'd2,
        OP_SOURCE = 3'd3,
        OP_ACK    = 3'd4
    } xirq_op_e;

    typedef struct packed {
        xirq_op_e        op;
        logic [ID_W-1:0] core;
        logic [ID_W-1:0] param;
    } xirq_cmd_t;

    function automatic logic id_in_range(input logic [ID_W-1:0] id, input int n);
        return ({1'b0, id} < (ID_W+1)'(n));
    endfunction

endpackage

// File: rtl/xirq_decode.sv
module xirq_decode
    import xirq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                                cmd_valid,
    input  xirq_cmd_t                           cmd,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0] set_m,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_m,
    output logic                                rd_status,
    output logic                                rd_source
);

    logic core_ok;
    logic param_ok;

    always_comb begin
        core_ok   = id_in_range(cmd.core, NUM_CORES);
        param_ok  = id_in_range(cmd.param, NUM_CORES);
        set_m     = '0;
        clr_m     = '0;
        rd_status = 1'b0;
        rd_source = 1'b0;
        if (cmd_valid && core_ok) begin
            for (int t = 0; t < NUM_CORES; t++) begin
                for (int s = 0; s < NUM_CORES; s++) begin
                    // raise: row = target (param), column = sender (core)
                    if (cmd.op == OP_RAISE && param_ok && cmd.param != cmd.core &&
                        cmd.param == ID_W'(t) && cmd.core == ID_W'(s))
                        set_m[t][s] = 1'b1;
                    // acknowledge: row = issuer, column = sender named by param
                    if (cmd.op == OP_ACK && param_ok &&
                        cmd.core == ID_W'(t) && cmd.param == ID_W'(s))
                        clr_m[t][s] = 1'b1;
                end
            end
            rd_status = (cmd.op == OP_STATUS) && param_ok;
            rd_source = (cmd.op == OP_SOURCE);
        end
    end

endmodule

// File: rtl/xirq_slot.sv
module xirq_slot #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] set_i,
    input  logic [NUM_CORES-1:0] clr_i,
    output logic [NUM_CORES-1:0] src_o,
    output logic                 irq_o
);

    logic [NUM_CORES-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= (src_q | set_i) & ~clr_i;
    end

    assign src_o = src_q;
    assign irq_o = |src_q;

    // R6: a cleared bit never survives the edge that clears it
    p_clr_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((src_q & $past(clr_i)) == '0));

endmodule

// File: rtl/xirq_readback.sv
module xirq_readback
    import xirq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                rd_status,
    input  logic                                rd_source,
    input  logic [ID_W-1:0]                     core,
    input  logic [ID_W-1:0]                     param,
    input  logic [NUM_CORES-1:0][NUM_CORES-1:0] src,
    output logic [NUM_CORES-1:0]                rb_o
);

    logic [NUM_CORES-1:0] rb_q;
    logic                 pend_sel;
    logic [NUM_CORES-1:0] map_sel;

    always_comb begin
        pend_sel = 1'b0;
        map_sel  = '0;
        for (int t = 0; t < NUM_CORES; t++) begin
            if (param == ID_W'(t)) pend_sel = |src[t];
            if (core == ID_W'(t))  map_sel  = src[t];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            rb_q <= '0;
        else if (rd_status) rb_q <= NUM_CORES'(pend_sel);
        else if (rd_source) rb_q <= map_sel;
    end

    assign rb_o = rb_q;

    // R8: readback holds unless a query is taken
    p_rb_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_status || rd_source) |=> $stable(rb_q));

endmodule

// File: rtl/xirq_gen_top.sv
module xirq_gen_top
    import xirq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [ID_W-1:0]      cmd_core,
    input  logic [2:0]           cmd_op,
    input  logic [ID_W-1:0]      cmd_param,
    output logic [NUM_CORES-1:0] readback,
    output logic [NUM_CORES-1:0] irq
);

    xirq_cmd_t                           cmd;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] set_m;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_m;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] src;
    logic                                rd_status;
    logic                                rd_source;

    assign cmd.op    = xirq_op_e'(cmd_op);
    assign cmd.core  = cmd_core;
    assign cmd.param = cmd_param;

    xirq_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .set_m     (set_m),
        .clr_m     (clr_m),
        .rd_status (rd_status),
        .rd_source (rd_source)
    );

    for (genvar t = 0; t < NUM_CORES; t++) begin : g_slot
        xirq_slot #(.NUM_CORES(NUM_CORES)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_m[t]),
            .clr_i (clr_m[t]),
            .src_o (src[t]),
            .irq_o (irq[t])
        );

        // R1: a legal raise sets the sender bit and the line
        p_raise_sets_r1: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_op == OP_RAISE && cmd_param == ID_W'(t) &&
             cmd_core != cmd_param && id_in_range(cmd_core, NUM_CORES))
            |=> (src[t][$past(cmd_core)] && irq[t]));

        // R6: acknowledge clears exactly the named bit
        p_ack_exact_r6: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_op == OP_ACK && cmd_core == ID_W'(t) &&
             id_in_range(cmd_param, NUM_CORES))
            |=> (src[t] == ($past(src[t]) & ~(NUM_CORES'(1) << $past(cmd_param)))));

        // R7: clearing the last sender drops the line on the next edge
        p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_op == OP_ACK && cmd_core == ID_W'(t) &&
             src[t] == (NUM_CORES'(1) << cmd_param))
            |=> !irq[t]);
    end

    xirq_readback #(.NUM_CORES(NUM_CORES)) u_rb (
        .clk       (clk),
        .rst       (rst),
        .rd_status (rd_status),
        .rd_source (rd_source),
        .core      (cmd_core),
        .param     (cmd_param),
        .src       (src),
        .rb_o      (readback)
    );

    // R2: self-directed raise is inert
    p_self_noop_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RAISE && cmd_core == cmd_param) |=> $stable(src));

    // R10: a raise on an already-set bit leaves the state as is
    p_dup_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RAISE && id_in_range(cmd_core, NUM_CORES) &&
         id_in_range(cmd_param, NUM_CORES) && src[cmd_param][cmd_core])
        |=> $stable(src));

    // R3: status query reports pending state of the target
    p_status_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_STATUS && id_in_range(cmd_core, NUM_CORES) &&
         id_in_range(cmd_param, NUM_CORES))
        |=> (readback == NUM_CORES'($past(irq[cmd_param]))));

endmodule

// File: tb/xirq_gen_top_test.sv
`timescale 1ns/1ps
module xirq_gen_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       v4 = 1'b0, v3 = 1'b0;
    logic [1:0] c4 = '0, p4 = '0, c3 = '0, p3 = '0;
    logic [2:0] o4 = '0, o3 = '0;
    logic [3:0] rb4, irq4;
    logic [2:0] rb3, irq3;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    xirq_gen_top #(.NUM_CORES(4)) uut (
        .clk(clk), .rst(rst), .cmd_valid(v4), .cmd_core(c4), .cmd_op(o4),
        .cmd_param(p4), .readback(rb4), .irq(irq4));

    xirq_gen_top #(.NUM_CORES(3)) uut3 (
        .clk(clk), .rst(rst), .cmd_valid(v3), .cmd_core(c3), .cmd_op(o3),
        .cmd_param(p3), .readback(rb3), .irq(irq3));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] core, input logic [2:0] op, input logic [1:0] par);
        @(negedge clk);
        v4 = 1'b1; c4 = core; o4 = op; p4 = par;
        @(negedge clk);
        v4 = 1'b0;
    endtask

    task automatic cmd3(input logic [1:0] core, input logic [2:0] op, input logic [1:0] par);
        @(negedge clk);
        v3 = 1'b1; c3 = core; o3 = op; p3 = par;
        @(negedge clk);
        v3 = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 irq after reset", irq4, 4'b0000);
        chk("R9 readback after reset", rb4, 4'b0000);
        chk("R9 irq after reset (3 cores)", {1'b0, irq3}, 4'b0000);
    endtask

    task automatic t_raise;
        cmd(0, 3'd1, 2);
        chk("R1 raise 0->2", irq4, 4'b0100);
        cmd(2, 3'd3, 0);
        chk("R4 source map of core 2", rb4, 4'b0001);
        cmd(1, 3'd2, 2);
        chk("R3 status of pending core 2", rb4, 4'b0001);
        cmd(1, 3'd2, 3);
        chk("R3 status of idle core 3", rb4, 4'b0000);
    endtask

    task automatic t_self;
        cmd(1, 3'd1, 1);
        chk("R2 self raise lines", irq4, 4'b0100);
        cmd(1, 3'd3, 0);
        chk("R2 self raise map", rb4, 4'b0000);
    endtask

    task automatic t_merge;
        cmd(1, 3'd1, 2);
        cmd(3, 3'd1, 2);
        chk("R5 single line", irq4, 4'b0100);
        cmd(2, 3'd3, 0);
        chk("R5 merged map", rb4, 4'b1011);
        cmd(0, 3'd1, 2);
        cmd(2, 3'd3, 0);
        chk("R10 duplicate raise", rb4, 4'b1011);
    endtask

    task automatic t_hold;
        cmd(3, 3'd1, 0);
        chk("R1 raise 3->0", irq4, 4'b0101);
        chk("R8 readback held over raise", rb4, 4'b1011);
        cmd(0, 3'd0, 1);
        cmd(1, 3'd7, 2);
        cmd(2, 3'd5, 0);
        chk("R8 nop/reserved readback", rb4, 4'b1011);
        chk("R8 nop/reserved lines", irq4, 4'b0101);
        cmd(0, 3'd3, 0);
        chk("R4 source map of core 0", rb4, 4'b1000);
        cmd(0, 3'd4, 3);
        chk("R7 core 0 line drops", irq4, 4'b0100);
    endtask

    task automatic t_ack;
        cmd(2, 3'd4, 1);
        cmd(2, 3'd3, 0);
        chk("R6 ack sender 1", rb4, 4'b1001);
        chk("R7 line held with senders left", irq4, 4'b0100);
        cmd(2, 3'd4, 2);
        cmd(2, 3'd3, 0);
        chk("R6 ack of clear bit", rb4, 4'b1001);
        cmd(2, 3'd4, 0);
        chk("R7 line held with one sender", irq4, 4'b0100);
        cmd(2, 3'd4, 3);
        chk("R7 line drops after last ack", irq4, 4'b0000);
        cmd(1, 3'd2, 2);
        chk("R3 status after ack", rb4, 4'b0000);
    endtask

    task automatic t_range;
        cmd3(0, 3'd1, 2);
        chk("R1 raise 0->2 (3 cores)", {1'b0, irq3}, 4'b0100);
        cmd3(0, 3'd1, 3);
        chk("R11 target out of range", {1'b0, irq3}, 4'b0100);
        cmd3(3, 3'd1, 0);
        chk("R11 issuer out of range", {1'b0, irq3}, 4'b0100);
        cmd3(2, 3'd3, 0);
        chk("R4 source map (3 cores)", {1'b0, rb3}, 4'b0001);
        cmd3(1, 3'd2, 3);
        chk("R11 status out of range", {1'b0, rb3}, 4'b0001);
        cmd3(2, 3'd4, 3);
        chk("R11 ack out of range", {1'b0, irq3}, 4'b0100);
        cmd3(2, 3'd4, 0);
        chk("R7 drop (3 cores)", {1'b0, irq3}, 4'b0000);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raise();
        t_self();
        t_merge();
        t_hold();
        t_ack();
        t_range();
        finish_run();
    end

endmodule